// File: doc/BRIEF.md
# I2C Slave Register Port

This block is a slave-only I2C target that gives a bus master access to a small bank of 8-bit registers. The SDA line is split into an input pin and an open-drain style output pin (`sda_out` low means pull the line low, high means release it), and SCL is input only. The block never drives SCL and never starts a transfer. Both lines are resynchronised into a system clock that runs at least eight times faster than SCL, so bus rates up to 400 kb/s are handled.

After a START the master shifts in a select byte, MSB first: seven address bits and a direction bit. The address the block answers to is picked by a static strap input. On a match the block acknowledges. In a write, the next byte becomes the register pointer and the bytes after it are stored one by one. In a read, the block returns register contents starting at the pointer. The pointer advances after every data byte in either direction. A repeated START re-enters address matching and keeps the pointer, so a write of just the pointer followed by a repeated START and a read gives random-access reads.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset `sda_out` is 1 (released) and every register reads back as 0x00.
- R2: A STOP (SDA rising while SCL is high) ends the transfer: the block releases SDA and ignores all further SCL pulses until the next START (SDA falling while SCL is high).
- R3: The select byte is sampled on SCL rising edges, MSB first. Bits [7:1] are the device address and bit 0 is the direction (1 read, 0 write). The address is 0x1C when `sel_strap` is 0 and 0x1D when it is 1 (select bytes 0x38/0x39 and 0x3A/0x3B). On a match `sda_out` is 0 throughout the 9th SCL high phase.
- R4: When the select byte does not match, the block does not acknowledge, does not drive SDA and leaves all registers unchanged until the next START.
- R5: In a write, the byte after the select byte is acknowledged and sets the register pointer to its value modulo REG_COUNT (16 by default, so 0x13 selects register 3).
- R6: Each later write byte is acknowledged, stored at the pointer, and the pointer then advances by one, wrapping from REG_COUNT-1 to 0.
- R7: In a read, the block drives the register at the pointer MSB first, one bit per SCL period, changing the bit only while SCL is low. The pointer advances by one (with wrap) after each byte. A read with no pointer byte before it continues from the current pointer.
- R8: During the master's acknowledge slot of a read the block releases SDA. After a NACK (SDA high in that slot) it drives nothing more until the next START.
- R9: A repeated START in the middle of a transfer restarts address matching with a clear bit count and keeps the register pointer.
- R10: `sda_out` only falls while SCL is low. A released line is never pulled low during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_strap | input | 1 | Static strap selecting address 0x1C (0) or 0x1D (1) |
| scl_in | input | 1 | I2C clock from the bus |
| sda_in | input | 1 | I2C data as seen on the bus |
| sda_out | output | 1 | I2C data drive: 0 pulls the line low, 1 releases it |

## Verification
Every wrong internal state ends up on `sda_out` in an SCL high phase, at the latest in the next acknowledge slot or read bit. A bad bit counter or phase moves the ACK pulse by one bit. A mismatched address decode shows as an ACK that is missing or one that should not be there. A wrong pointer or a store that never happened shows within the eight bits of the next byte read back. The reference model predicts the level on `sda_out` in every clock of every SCL high window, so an error is reported in the SCL period where it first becomes visible, not at the end of the transfer.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  // transfer phase of the slave
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SEL,
    PH_SEL_ACK,
    PH_SUB,
    PH_SUB_ACK,
    PH_WR,
    PH_WR_ACK,
    PH_RD,
    PH_RD_ACK
  } phase_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] row_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row_we
    assign row_we[g] = wr_en && (wr_idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (row_we[i]) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_regport_pkg::*;
#(
  parameter logic [6:0] ADDR_LO   = 7'h1C,
  parameter logic [6:0] ADDR_HI   = 7'h1D,
  parameter int         REG_COUNT = 16,
  parameter int         SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_strap,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out
);
  localparam int IW    = $clog2(REG_COUNT);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_regport_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  phase_t              phase_q, phase_d;
  logic [CNT_W-1:0]    bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-1:0]   shreg_q, shreg_d;
  logic [IW-1:0]       ptr_q, ptr_d;
  logic                rw_q, rw_d;
  logic                mnack_q, mnack_d;
  logic                wr_en;
  logic [BYTE_W-1:0]   rd_data;
  logic [6:0]          own_addr;

  i2c_regport_bank #(.DEPTH(REG_COUNT), .DW(BYTE_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (ptr_q),
    .wr_data (shreg_q),
    .rd_idx  (ptr_q),
    .rd_data (rd_data)
  );

  assign own_addr = sel_strap ? ADDR_HI : ADDR_LO;

  // next-state logic
  always_comb begin
    phase_d   = phase_q;
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    ptr_d     = ptr_q;
    rw_d      = rw_q;
    mnack_d   = mnack_q;
    wr_en     = 1'b0;

    if (bus_start) begin
      phase_d   = PH_SEL;
      bit_cnt_d = '0;
    end else if (bus_stop) begin
      phase_d   = PH_IDLE;
      bit_cnt_d = '0;
    end else begin
      unique case (phase_q)
        PH_SEL, PH_SUB, PH_WR: begin
          if (scl_rise) begin
            shreg_d   = {shreg_q[BYTE_W-2:0], sda_lvl};
            bit_cnt_d = bit_cnt_q + 1'b1;
          end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
            bit_cnt_d = '0;
            if (phase_q == PH_SEL) begin
              if (shreg_q[BYTE_W-1:1] == own_addr) begin
                rw_d    = shreg_q[0];
                phase_d = PH_SEL_ACK;
              end else begin
                phase_d = PH_IDLE;
              end
            end else if (phase_q == PH_SUB) begin
              ptr_d   = shreg_q[IW-1:0];
              phase_d = PH_SUB_ACK;
            end else begin
              wr_en   = 1'b1;
              ptr_d   = ptr_q + 1'b1;
              phase_d = PH_WR_ACK;
            end
          end
        end
        PH_SEL_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              phase_d = PH_RD;
              shreg_d = rd_data;
            end else begin
              phase_d = PH_SUB;
            end
          end
        end
        PH_SUB_ACK, PH_WR_ACK: begin
          if (scl_fall) phase_d = PH_WR;
        end
        PH_RD: begin
          if (scl_rise) begin
            bit_cnt_d = bit_cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt_q == LAST_BIT) begin
              bit_cnt_d = '0;
              ptr_d     = ptr_q + 1'b1;
              phase_d   = PH_RD_ACK;
            end else begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        PH_RD_ACK: begin
          if (scl_rise) begin
            mnack_d = sda_lvl;
          end else if (scl_fall) begin
            if (mnack_q) begin
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_RD;
              shreg_d = rd_data;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mnack_q   <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      ptr_q     <= ptr_d;
      rw_q      <= rw_d;
      mnack_q   <= mnack_d;
    end
  end

  // drive low only from registered state
  always_comb begin
    unique case (phase_q)
      PH_SEL_ACK, PH_SUB_ACK, PH_WR_ACK: sda_out = 1'b0;
      PH_RD:                             sda_out = shreg_q[BYTE_W-1];
      default:                           sda_out = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
  import i2c_regport_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             scl_fall,
  input logic             bus_start,
  input logic             bus_stop,
  input logic             wr_en,
  input phase_t           phase,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             mnack,
  input logic             sda_out
);
  // R10
  no_fall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> !$fell(sda_out));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> sda_out);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (sda_out && phase == PH_IDLE));

  // R6
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !sda_out);

  // R3
  bit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(BYTE_W));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (phase == PH_SEL && bit_cnt == '0 && sda_out));

  // R8
  nack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD_ACK && mnack && scl_fall && !bus_start && !bus_stop) |=> (phase == PH_IDLE));
endmodule

bind i2c_regport_slave i2c_regport_chk #(.CNT_W(4)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_lvl   (scl_lvl),
  .scl_fall  (scl_fall),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .wr_en     (wr_en),
  .phase     (phase_q),
  .bit_cnt   (bit_cnt_q),
  .mnack     (mnack_q),
  .sda_out   (sda_out)
);

// File: tb/i2c_regport_slave_bench.sv
module i2c_regport_slave_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, sda_m, strap;
  logic sda_out_w;
  wire  sda_bus = sda_m & sda_out_w;

  i2c_regport_slave u_i2c_regport_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_strap (strap),
    .scl_in    (scl),
    .sda_in    (sda_bus),
    .sda_out   (sda_out_w)
  );

  int    total = 0;
  int    bad   = 0;
  bit    chk_on = 1'b0;
  bit    done   = 1'b0;
  logic  exp_sda = 1'b1;
  string cur_req = "R1";

  // behavioural model of the register file and pointer
  logic [7:0] mdl_regs [16];
  int         mdl_ptr = 0;

  // compare the drive level on every clock of each SCL high window
  always @(negedge clk) begin
    if (chk_on && !done) begin
      total++;
      if (sda_out_w !== exp_sda) begin
        bad++;
        $display("FAIL %s: sda_out=%b expected %b at %0t", cur_req, sda_out_w, exp_sda, $time);
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic slot(input logic mbit, input logic exp, output logic seen);
    ticks(10); sda_m = mbit;
    ticks(10); scl = 1'b1;
    ticks(5);  exp_sda = exp; chk_on = 1'b1;
    ticks(10); chk_on = 1'b0; seen = sda_bus;
    ticks(5);  scl = 1'b0;
  endtask

  task automatic do_start();
    if (scl == 1'b0) begin
      ticks(10); sda_m = 1'b1;
      ticks(10); scl = 1'b1;
    end
    ticks(10); sda_m = 1'b0;
    ticks(10); scl = 1'b0;
  endtask

  task automatic do_stop();
    ticks(10); sda_m = 1'b0;
    ticks(10); scl = 1'b1;
    ticks(10); sda_m = 1'b1;
    ticks(10);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic seen;
    cur_req = req;
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b1, seen);
    slot(1'b1, exp_ack ? 1'b0 : 1'b1, seen);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
    logic seen;
    logic [7:0] got;
    cur_req = req;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, exp[i], seen);
      got[i] = seen;
    end
    slot(mack ? 1'b0 : 1'b1, 1'b1, seen);
    check8(req, got, exp);
  endtask

  function automatic logic addr_hit(input logic [6:0] a7);
    return a7 == (strap ? 7'h1D : 7'h1C);
  endfunction

  task automatic wr_txn(input logic [6:0] a7, input logic [7:0] sub, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input string req);
    logic hit;
    logic [7:0] d;
    hit = addr_hit(a7);
    do_start();
    send_byte({a7, 1'b0}, hit, req);
    send_byte(sub, hit, req);
    if (hit) mdl_ptr = sub % 16;
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : d1;
      send_byte(d, hit, req);
      if (hit) begin
        mdl_regs[mdl_ptr] = d;
        mdl_ptr = (mdl_ptr + 1) % 16;
      end
    end
    do_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a7, input bit use_sub, input logic [7:0] sub,
                        input int n, input string req);
    logic hit;
    hit = addr_hit(a7);
    do_start();
    if (use_sub) begin
      send_byte({a7, 1'b0}, hit, req);
      send_byte(sub, hit, req);
      if (hit) mdl_ptr = sub % 16;
      do_start();
    end
    send_byte({a7, 1'b1}, hit, req);
    for (int k = 0; k < n; k++) begin
      if (hit) begin
        recv_byte(mdl_regs[mdl_ptr], k < n - 1, req);
        mdl_ptr = (mdl_ptr + 1) % 16;
      end else begin
        recv_byte(8'hFF, k < n - 1, req);
      end
    end
    do_stop();
  endtask

  initial begin
    logic seen;
    for (int i = 0; i < 16; i++) mdl_regs[i] = 8'h00;
    scl = 1'b1; sda_m = 1'b1; strap = 1'b0; rst_n = 1'b0;
    ticks(5);
    total++;
    if (sda_out_w !== 1'b1) begin
      bad++;
      $display("FAIL R1: sda_out=%b expected 1 in reset", sda_out_w);
    end
    rst_n = 1'b1;
    ticks(10);
    total++;
    if (sda_out_w !== 1'b1) begin
      bad++;
      $display("FAIL R1: sda_out=%b expected 1 after reset", sda_out_w);
    end

    // R1: registers are clear after reset
    rd_txn(7'h1C, 1'b1, 8'h00, 4, "R1");

    // R3 R5 R6: write with strap low
    wr_txn(7'h1C, 8'h02, 2, 8'hA5, 8'h3C, "R6");
    // R7 R9: pointer write, repeated start, read back
    rd_txn(7'h1C, 1'b1, 8'h02, 2, "R9");
    // R7: read with no pointer byte continues from the pointer
    rd_txn(7'h1C, 1'b0, 8'h00, 2, "R7");

    // R4: wrong address leaves registers untouched
    wr_txn(7'h1D, 8'h02, 2, 8'hEE, 8'hEE, "R4");
    rd_txn(7'h1D, 1'b1, 8'h02, 1, "R4");
    rd_txn(7'h1C, 1'b1, 8'h02, 2, "R4");

    // R5: pointer byte taken modulo 16
    wr_txn(7'h1C, 8'h13, 1, 8'h77, 8'h00, "R5");
    rd_txn(7'h1C, 1'b1, 8'h03, 1, "R5");

    // R3 R6: strap high, write across the wrap
    strap = 1'b1;
    wr_txn(7'h1D, 8'h0F, 2, 8'h11, 8'h22, "R3");
    rd_txn(7'h1D, 1'b1, 8'h0F, 2, "R6");
    wr_txn(7'h1C, 8'h04, 1, 8'h99, 8'h00, "R3");
    rd_txn(7'h1D, 1'b1, 8'h04, 1, "R3");

    // R2: after STOP, clocked bits with no START are ignored
    strap = 1'b0;
    do_start();
    send_byte(8'h38, 1'b1, "R2");
    send_byte(8'h05, 1'b1, "R2");
    mdl_ptr = 5;
    do_stop();
    cur_req = "R2";
    ticks(10); scl = 1'b0;
    for (int i = 7; i >= 0; i--) slot(logic'(8'h38 >> i), 1'b1, seen);
    slot(1'b1, 1'b1, seen);
    for (int i = 7; i >= 0; i--) slot(logic'(8'h5A >> i), 1'b1, seen);
    slot(1'b1, 1'b1, seen);
    do_stop();
    rd_txn(7'h1C, 1'b1, 8'h05, 1, "R2");

    // R8: after a NACK the line stays released
    do_start();
    send_byte(8'h39, 1'b1, "R8");
    recv_byte(mdl_regs[mdl_ptr], 1'b0, "R8");
    mdl_ptr = (mdl_ptr + 1) % 16;
    cur_req = "R8";
    for (int i = 0; i < 9; i++) slot(1'b1, 1'b1, seen);
    do_stop();
    // R7 R10: pointer advanced past the NACKed byte
    rd_txn(7'h1C, 1'b0, 8'h00, 1, "R7");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule